// File: doc/BRIEF.md
# Instrument Status Byte and Service-Request Generator

This block keeps the status-reporting state of a remotely controlled instrument and condenses it into an 8-bit status byte and a service-request line for the host controller. It has two sticky event registers, one for standard events and one for extended events. Each register is set by one-cycle per-bit pulses and cleared when it is read. Each register is summarised through its own enable mask into one status bit. Two more status bits follow the empty flags of an external output queue and an external error queue.

The status byte, with the request bit left out, is ANDed with a service-request enable mask to form a live master summary. The request bit is armed by an edge. It is set one cycle after the master summary rises. It clears after a serial poll, or after the summary drops back to zero. The byte is presented in two forms. The query form carries the live master summary in bit 6. The serial-poll form carries the armed request bit in bit 6.

The command parser, both queues and the filtering of extended conditions belong to other blocks. Extended events arrive here already filtered.

Top module: `stat_req_gen`

## Requirements
- R1: After reset every register reads zero, `serviceReq` is 0, and with both queues empty `statusByte` and `pollByte` are 8'h00.
- R2: Bits 7, 1 and 0 of `statusByte` and `pollByte` are always 0.
- R3: Bit 2 of the status byte equals NOT `errQueueEmpty`, and bit 4 equals NOT `outQueueEmpty`, in the same cycle.
- R4: Bit 5 of the status byte is 1 exactly when the standard event register ANDed with the standard enable mask is nonzero.
- R5: Bit 3 of the status byte is 1 exactly when the extended event register ANDed with the extended enable mask is nonzero.
- R6: Each event register keeps a bit set from its pulse until a read strobe. During the read cycle `stdEvtVal`/`extEvtVal` shows the accumulated value. After that edge the register holds only the pulses that arrived in the read cycle.
- R7: Bit 6 of `statusByte` (master summary) is 1 exactly when `statusByte` with bit 6 forced to 0, ANDed with the service-request enable mask, is nonzero.
- R8: Bit 6 of `srqEnData` is dropped on write, and `srqEnVal[6]` reads 0. A status bit whose enable bit is 0 never raises `serviceReq`. The enable masks read back as written.
- R9: `serviceReq` rises at the clock edge after the cycle in which the master summary goes from 0 to 1. `pollByte` bit 6 equals `serviceReq`. The other bits of `pollByte` equal those of `statusByte`.
- R10: A `pollStrobe` clears `serviceReq` at the next edge. The request is not re-armed while the master summary stays 1.
- R11: If the master summary is 0 at a clock edge, `serviceReq` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stdEvtSet | input | STD_W | Per-bit set pulses for the standard event register |
| extEvtSet | input | EXT_W | Per-bit set pulses for the extended event register |
| outQueueEmpty | input | 1 | Output queue is empty |
| errQueueEmpty | input | 1 | Error queue is empty |
| srqEnWr | input | 1 | Write strobe for the service-request enable mask |
| srqEnData | input | 8 | Service-request enable write data |
| stdEnWr | input | 1 | Write strobe for the standard enable mask |
| stdEnData | input | STD_W | Standard enable write data |
| extEnWr | input | 1 | Write strobe for the extended enable mask |
| extEnData | input | EXT_W | Extended enable write data |
| pollStrobe | input | 1 | Serial-poll strobe |
| stdRead | input | 1 | Read-and-clear strobe for the standard event register |
| extRead | input | 1 | Read-and-clear strobe for the extended event register |
| statusByte | output | 8 | Query form of the status byte (bit 6 = master summary) |
| pollByte | output | 8 | Serial-poll form of the status byte (bit 6 = request) |
| stdEvtVal | output | STD_W | Standard event register value |
| extEvtVal | output | EXT_W | Extended event register value |
| srqEnVal | output | 8 | Service-request enable mask readback |
| stdEnVal | output | STD_W | Standard enable mask readback |
| extEnVal | output | EXT_W | Extended enable mask readback |
| serviceReq | output | 1 | Service-request line |

## Verification
A wrong bit in an event register or an enable mask appears at once on the readback outputs. In the same cycle it also changes the combinational summary bits of `statusByte`. A wrong request-arming state shows one edge later on `serviceReq` and `pollByte` bit 6, in one of three ways:
- a request that fails to rise after the master summary rises;
- a request that survives a poll;
- a request that re-arms without a fresh rising edge.

Read-clear faults show on the next edge. An event pulse lost during a read leaves the register at zero when it should hold the new pulse.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int SB_W    = 8;
  localparam int SB_EAV  = 2;
  localparam int SB_EES  = 3;
  localparam int SB_MAV  = 4;
  localparam int SB_ESB  = 5;
  localparam int SB_SUMM = 6;

  // mask that removes the summary position from any byte-wide value
  localparam logic [SB_W-1:0] NO_SUMM = ~(SB_W'(1) << SB_SUMM);

  typedef struct packed {
    logic clrStd;
    logic clrExt;
  } srqStrobes_t;
endpackage

// File: rtl/srq_summary.sv
module srq_summary #(
  parameter int W = 8
) (
  input  logic [W-1:0] evt,
  input  logic [W-1:0] en,
  output logic         hit
);
  logic [W-1:0] andBits;

  for (genvar i = 0; i < W; i++) begin : g_and
    assign andBits[i] = evt[i] & en[i];
  end

  assign hit = |andBits;
endmodule

// File: rtl/srq_datapath.sv
module srq_datapath
  import srq_pkg::*;
#(
  parameter int STD_W = 8,
  parameter int EXT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  srqStrobes_t       strb,
  input  logic [STD_W-1:0]  stdEvtSet,
  input  logic [EXT_W-1:0]  extEvtSet,
  input  logic              outQueueEmpty,
  input  logic              errQueueEmpty,
  input  logic              srqEnWr,
  input  logic [SB_W-1:0]   srqEnData,
  input  logic              stdEnWr,
  input  logic [STD_W-1:0]  stdEnData,
  input  logic              extEnWr,
  input  logic [EXT_W-1:0]  extEnData,
  input  logic              rqs,
  output logic [SB_W-1:0]   statusByte,
  output logic [SB_W-1:0]   pollByte,
  output logic [STD_W-1:0]  stdEvtVal,
  output logic [EXT_W-1:0]  extEvtVal,
  output logic [SB_W-1:0]   srqEnVal,
  output logic [STD_W-1:0]  stdEnVal,
  output logic [EXT_W-1:0]  extEnVal,
  output logic              mss
);
  logic [STD_W-1:0] stdReg, stdEnReg;
  logic [EXT_W-1:0] extReg, extEnReg;
  logic [SB_W-1:0]  srqEnReg;
  logic             esb, ees;
  logic [SB_W-1:0]  baseByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdReg   <= '0;
      extReg   <= '0;
      stdEnReg <= '0;
      extEnReg <= '0;
      srqEnReg <= '0;
    end else begin
      stdReg <= (strb.clrStd ? '0 : stdReg) | stdEvtSet;
      extReg <= (strb.clrExt ? '0 : extReg) | extEvtSet;
      if (stdEnWr) stdEnReg <= stdEnData;
      if (extEnWr) extEnReg <= extEnData;
      if (srqEnWr) srqEnReg <= srqEnData & NO_SUMM;
    end
  end

  srq_summary #(.W(STD_W)) u_stdSum (.evt(stdReg), .en(stdEnReg), .hit(esb));
  srq_summary #(.W(EXT_W)) u_extSum (.evt(extReg), .en(extEnReg), .hit(ees));

  always_comb begin
    baseByte         = '0;
    baseByte[SB_EAV] = ~errQueueEmpty;
    baseByte[SB_EES] = ees;
    baseByte[SB_MAV] = ~outQueueEmpty;
    baseByte[SB_ESB] = esb;
  end

  srq_summary #(.W(SB_W)) u_mssSum (.evt(baseByte), .en(srqEnReg), .hit(mss));

  always_comb begin
    statusByte          = baseByte;
    statusByte[SB_SUMM] = mss;
    pollByte            = baseByte;
    pollByte[SB_SUMM]   = rqs;
  end

  assign stdEvtVal = stdReg;
  assign extEvtVal = extReg;
  assign srqEnVal  = srqEnReg;
  assign stdEnVal  = stdEnReg;
  assign extEnVal  = extEnReg;
endmodule

// File: rtl/srq_control.sv
module srq_control
  import srq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stdRead,
  input  logic        extRead,
  input  logic        pollStrobe,
  input  logic        mss,
  output srqStrobes_t strb,
  output logic        rqs
);
  logic mssPrev;
  logic mssRise;

  assign mssRise = mss & ~mssPrev;

  always_comb begin
    strb.clrStd = stdRead;
    strb.clrExt = extRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mssPrev <= 1'b0;
      rqs     <= 1'b0;
    end else begin
      mssPrev <= mss;
      if (mssRise)                rqs <= 1'b1;
      else if (pollStrobe || !mss) rqs <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_req_gen.sv
module stat_req_gen
  import srq_pkg::*;
#(
  parameter int STD_W = 8,
  parameter int EXT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [STD_W-1:0] stdEvtSet,
  input  logic [EXT_W-1:0] extEvtSet,
  input  logic             outQueueEmpty,
  input  logic             errQueueEmpty,
  input  logic             srqEnWr,
  input  logic [7:0]       srqEnData,
  input  logic             stdEnWr,
  input  logic [STD_W-1:0] stdEnData,
  input  logic             extEnWr,
  input  logic [EXT_W-1:0] extEnData,
  input  logic             pollStrobe,
  input  logic             stdRead,
  input  logic             extRead,
  output logic [7:0]       statusByte,
  output logic [7:0]       pollByte,
  output logic [STD_W-1:0] stdEvtVal,
  output logic [EXT_W-1:0] extEvtVal,
  output logic [7:0]       srqEnVal,
  output logic [STD_W-1:0] stdEnVal,
  output logic [EXT_W-1:0] extEnVal,
  output logic             serviceReq
);
  srqStrobes_t strb;
  logic        mss;
  logic        rqs;

  srq_control u_ctrl (
    .clk(clk), .rstN(rstN), .stdRead(stdRead), .extRead(extRead),
    .pollStrobe(pollStrobe), .mss(mss), .strb(strb), .rqs(rqs)
  );

  srq_datapath #(.STD_W(STD_W), .EXT_W(EXT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .stdEvtSet(stdEvtSet), .extEvtSet(extEvtSet),
    .outQueueEmpty(outQueueEmpty), .errQueueEmpty(errQueueEmpty),
    .srqEnWr(srqEnWr), .srqEnData(srqEnData),
    .stdEnWr(stdEnWr), .stdEnData(stdEnData),
    .extEnWr(extEnWr), .extEnData(extEnData),
    .rqs(rqs), .statusByte(statusByte), .pollByte(pollByte),
    .stdEvtVal(stdEvtVal), .extEvtVal(extEvtVal),
    .srqEnVal(srqEnVal), .stdEnVal(stdEnVal), .extEnVal(extEnVal),
    .mss(mss)
  );

  assign serviceReq = rqs;
endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
  parameter int STD_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             errQueueEmpty,
  input logic             outQueueEmpty,
  input logic             pollStrobe,
  input logic             stdRead,
  input logic [7:0]       statusByte,
  input logic [7:0]       pollByte,
  input logic [STD_W-1:0] stdEvtVal,
  input logic [7:0]       srqEnVal,
  input logic             serviceReq
);
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] == 1'b0) && (statusByte[1:0] == 2'b00)); // R2
  AST_QUEUE_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[2] == !errQueueEmpty) && (statusByte[4] == !outQueueEmpty)); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stdRead |=> ((stdEvtVal & $past(stdEvtVal)) == $past(stdEvtVal))); // R6
  AST_SUMM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6] |-> (|(srqEnVal & statusByte & 8'hBF))); // R7
  AST_EN6_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    srqEnVal[6] == 1'b0); // R8
  AST_REQ_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[6]) |=> serviceReq); // R9
  AST_POLL_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (pollByte[6] == serviceReq) && ((pollByte & 8'hBF) == (statusByte & 8'hBF))); // R9
  AST_POLL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (pollStrobe && !$rose(statusByte[6])) |=> !serviceReq); // R10
  AST_SUMM_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[6] |=> !serviceReq); // R11
endmodule

bind stat_req_gen srq_checker #(.STD_W(STD_W)) u_chk (
  .clk(clk), .rstN(rstN), .errQueueEmpty(errQueueEmpty),
  .outQueueEmpty(outQueueEmpty), .pollStrobe(pollStrobe), .stdRead(stdRead),
  .statusByte(statusByte), .pollByte(pollByte), .stdEvtVal(stdEvtVal),
  .srqEnVal(srqEnVal), .serviceReq(serviceReq)
);

// File: tb/sim_stat_req_gen.sv
module sim_stat_req_gen;
  localparam int STD_W = 8;
  localparam int EXT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [STD_W-1:0] stdEvtSet = '0;
  logic [EXT_W-1:0] extEvtSet = '0;
  logic outQueueEmpty = 1'b1, errQueueEmpty = 1'b1;
  logic srqEnWr = 1'b0, stdEnWr = 1'b0, extEnWr = 1'b0;
  logic [7:0] srqEnData = '0;
  logic [STD_W-1:0] stdEnData = '0;
  logic [EXT_W-1:0] extEnData = '0;
  logic pollStrobe = 1'b0, stdRead = 1'b0, extRead = 1'b0;
  logic [7:0] statusByte, pollByte, srqEnVal;
  logic [STD_W-1:0] stdEvtVal, stdEnVal;
  logic [EXT_W-1:0] extEvtVal, extEnVal;
  logic serviceReq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stat_req_gen #(.STD_W(STD_W), .EXT_W(EXT_W)) u0 (
    .clk(clk), .rstN(rstN), .stdEvtSet(stdEvtSet), .extEvtSet(extEvtSet),
    .outQueueEmpty(outQueueEmpty), .errQueueEmpty(errQueueEmpty),
    .srqEnWr(srqEnWr), .srqEnData(srqEnData), .stdEnWr(stdEnWr),
    .stdEnData(stdEnData), .extEnWr(extEnWr), .extEnData(extEnData),
    .pollStrobe(pollStrobe), .stdRead(stdRead), .extRead(extRead),
    .statusByte(statusByte), .pollByte(pollByte), .stdEvtVal(stdEvtVal),
    .extEvtVal(extEvtVal), .srqEnVal(srqEnVal), .stdEnVal(stdEnVal),
    .extEnVal(extEnVal), .serviceReq(serviceReq)
  );

  // {srq enable written, outQueueEmpty, errQueueEmpty, expected statusByte}
  typedef struct packed {
    logic [7:0] en;
    logic       oe;
    logic       ee;
    logic [7:0] expSb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hFF, 1'b1, 1'b1, 8'h00},
    '{8'hFF, 1'b0, 1'b1, 8'h50},
    '{8'hFF, 1'b1, 1'b0, 8'h44},
    '{8'h10, 1'b1, 1'b0, 8'h04},
    '{8'h04, 1'b1, 1'b0, 8'h44},
    '{8'h40, 1'b0, 1'b0, 8'h14},
    '{8'hAB, 1'b0, 1'b0, 8'h14},
    '{8'h14, 1'b0, 1'b0, 8'h54}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeSrq(input logic [7:0] d);
    srqEnWr = 1'b1; srqEnData = d; tick(); srqEnWr = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 statusByte", 32'(statusByte), 32'h00);
    chk("R1 pollByte", 32'(pollByte), 32'h00);
    chk("R1 serviceReq", 32'(serviceReq), 32'h0);
    chk("R1 regs", 32'({stdEvtVal, srqEnVal, stdEnVal}), 32'h0);
    chk("R1 ext", 32'({extEvtVal, extEnVal}), 32'h0);

    // vector table: R2 R3 R7 R8 combinational summary
    foreach (VECS[i]) begin
      outQueueEmpty = VECS[i].oe;
      errQueueEmpty = VECS[i].ee;
      writeSrq(VECS[i].en);
      chk("R3/R7 statusByte", 32'(statusByte), 32'(VECS[i].expSb));
      chk("R8 srqEnVal", 32'(srqEnVal), 32'(VECS[i].en & 8'hBF));
      chk("R2 spare bits", 32'(statusByte & 8'h83), 32'h0);
    end
    outQueueEmpty = 1'b1; errQueueEmpty = 1'b1;
    writeSrq(8'h00);
    tick();

    // R4 / R6 standard register
    stdEnWr = 1'b1; stdEnData = 8'h20; tick(); stdEnWr = 1'b0;
    chk("R8 stdEnVal", 32'(stdEnVal), 32'h20);
    stdEvtSet = 8'h01; tick(); stdEvtSet = '0;
    chk("R4 masked event", 32'(statusByte), 32'h00);
    chk("R6 sticky", 32'(stdEvtVal), 32'h01);
    stdEvtSet = 8'h20; tick(); stdEvtSet = '0;
    chk("R4 ESB set", 32'(statusByte), 32'h20);
    chk("R6 accumulate", 32'(stdEvtVal), 32'h21);
    stdRead = 1'b1; stdEvtSet = 8'h04; #1;
    chk("R6 read value", 32'(stdEvtVal), 32'h21);
    tick(); stdRead = 1'b0; stdEvtSet = '0;
    chk("R6 pulse kept on read", 32'(stdEvtVal), 32'h04);
    chk("R4 ESB cleared", 32'(statusByte), 32'h00);
    stdRead = 1'b1; tick(); stdRead = 1'b0;
    chk("R6 cleared", 32'(stdEvtVal), 32'h00);

    // R5 extended register
    extEnWr = 1'b1; extEnData = 16'h8000; tick(); extEnWr = 1'b0;
    chk("R8 extEnVal", 32'(extEnVal), 32'h8000);
    extEvtSet = 16'h8000; tick(); extEvtSet = '0;
    chk("R5 EES set", 32'(statusByte), 32'h08);
    extRead = 1'b1; tick(); extRead = 1'b0;
    chk("R5 EES cleared", 32'(statusByte), 32'h00);
    chk("R6 ext cleared", 32'(extEvtVal), 32'h0);

    // R9 request arming on the summary's rising edge
    writeSrq(8'h20);
    stdEvtSet = 8'h20; tick(); stdEvtSet = '0;
    chk("R7 summary live", 32'(statusByte), 32'h60);
    chk("R9 not yet armed", 32'(pollByte), 32'h20);
    tick();
    chk("R9 serviceReq", 32'(serviceReq), 32'h1);
    chk("R9 pollByte", 32'(pollByte), 32'h60);

    // R10 poll clears, no re-arm while summary stays high
    pollStrobe = 1'b1; #1;
    chk("R10 poll read", 32'(pollByte), 32'h60);
    tick(); pollStrobe = 1'b0;
    chk("R10 cleared", 32'(serviceReq), 32'h0);
    chk("R10 summary kept", 32'(statusByte), 32'h60);
    tick();
    chk("R10 no re-arm", 32'(serviceReq), 32'h0);

    // R11 clears when the summary drops
    stdRead = 1'b1; tick(); stdRead = 1'b0;
    stdEvtSet = 8'h20; tick(); stdEvtSet = '0;
    tick();
    chk("R9 re-armed", 32'(serviceReq), 32'h1);
    stdRead = 1'b1; tick(); stdRead = 1'b0;
    chk("R11 summary low", 32'(statusByte), 32'h00);
    chk("R11 still set", 32'(serviceReq), 32'h1);
    tick();
    chk("R11 cleared", 32'(serviceReq), 32'h0);

    // R8 masking of errors
    writeSrq(8'h10);
    errQueueEmpty = 1'b0; tick(); tick();
    chk("R8 masked EAV byte", 32'(statusByte), 32'h04);
    chk("R8 masked no request", 32'(serviceReq), 32'h0);
    writeSrq(8'h14); tick();
    chk("R8 unmasked request", 32'(serviceReq), 32'h1);
    errQueueEmpty = 1'b1;
    tick(); tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule